// File: doc/BRIEF.md
# Interrupt and Wake-up Controller

This block gathers three interrupt sources for a small 8-bit processor core: a timer overflow pulse, an active edge on the external interrupt line (which shares port B pin 0), and a change on port B input pins. Each source is held in its own sticky flag bit. Each flag is masked by its own enable bit, and all of them by a global enable. When an enabled flag is pending, the block raises a request together with the fixed hardware vector address. The core signals acceptance with a one-cycle acknowledge, and the block then drops the global enable.

While the core is asleep, a pending external-edge flag or a pending port-change flag raises a wake-up output. The global enable and the per-source enables have no effect on wake-up, so a sleeping core with interrupts masked still wakes and continues at its next instruction. Port change detection compares the synchronised pins against a snapshot. The core refreshes the snapshot each time it reads the port. Only pins whose wake-enable bit is set take part in the comparison.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the enable register, the flag register, `irq_req_o` and `wake_o` are all 0, and the port snapshot is 0.
- R2: The enable register keeps only bit 7 (global enable), bit 2 (external edge), bit 1 (port change) and bit 0 (timer). The flag register keeps bit 2 (external edge), bit 1 (port change) and bit 0 (timer). All other bits read as 0.
- R3: A `tmr_ovf_i` pulse sets flag bit 0 at the next clock edge, whatever the enables hold.
- R4: After synchronisation, a rising edge on pin 0 sets flag bit 2 when `int_rise_i` is 1, and a falling edge sets it when `int_rise_i` is 0. The opposite edge has no effect.
- R5: Flag bit 1 is set while any pin whose `wake_en_i` bit is 1 differs from the snapshot. Pins whose enable bit is 0 never set it.
- R6: A `pb_read_i` pulse loads the synchronised pins into the snapshot, so that after it, a software clear of flag bit 1 stays in effect.
- R7: Flags latch and are cleared only by a flag-register write. A source event in the same cycle as the write wins, and the bit stays 1.
- R8: `irq_req_o` is 1 exactly when the global enable is 1 and some flag bit is 1 together with its enable bit.
- R9: `irq_ack_i` clears the global enable at the next edge, and it takes priority over an enable-register write in the same cycle.
- R10: `wake_o` is 1 exactly when `sleep_i` is 1 and flag bit 2 or flag bit 1 is set. It does not depend on any enable bit.
- R11: `irq_vec_o` carries the hardware interrupt address 008h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| pb_pins_i | input | PB_W | Raw port B pins, asynchronous; pin 0 is also the external interrupt line |
| int_rise_i | input | 1 | External edge select: 1 selects rising, 0 selects falling |
| wake_en_i | input | PB_W | Per-pin enable for change detection |
| pb_read_i | input | 1 | Port read strobe; refreshes the snapshot |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| flag_we_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag register write data |
| irq_ack_i | input | 1 | Interrupt accepted by the core |
| sleep_i | input | 1 | Core is in sleep state |
| en_o | output | 8 | Enable register contents |
| flag_o | output | 8 | Flag register contents |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | PC_W | Hardware interrupt vector address |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest situation to reach is a masked, sleeping core woken by a port change on an enabled pin while a disabled pin also toggles. The stimulus takes a snapshot with a port read, clears every enable and the global enable, and raises sleep. It first toggles a pin with its wake-enable bit off and checks that nothing happens. It then toggles an enabled pin and checks that wake-up rises while the request stays low. A second hard case is the race between a software clear and a live port mismatch. The bench clears the port-change flag before and after a fresh port read and shows that only the cleared-after-read flag stays low.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
   localparam int REG_W   = 8;
   localparam int NSRC    = 3;
   localparam int GIE_BIT = 7;
   localparam int INT_BIT = 2;
   localparam int PB_BIT  = 1;
   localparam int T0_BIT  = 0;
   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/irq_int_edge.sv
module irq_int_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic evt
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= pin;
   end

   assign evt = rise_sel ? (pin & ~prev) : (~pin & prev);
endmodule

// File: rtl/irq_pb_change.sv
module irq_pb_change #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] wake_en,
   input  logic         snap_ld,
   output logic         change
);
   logic [W-1:0] snap;
   logic [W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap <= '0;
      else if (snap_ld) snap <= pins;
   end

   assign diff   = (pins ^ snap) & wake_en;
   assign change = |diff;
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags
   import irq_wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t set,
   input  logic     we,
   input  src_vec_t wdata,
   output src_vec_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (we ? wdata : q) | set;
   end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
   import irq_wake_pkg::*;
#(
   parameter int          PB_W        = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          PC_W        = 11,
   parameter logic [15:0] HW_VECTOR   = 16'h0008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_ovf_i,
   input  logic [PB_W-1:0]   pb_pins_i,
   input  logic              int_rise_i,
   input  logic [PB_W-1:0]   wake_en_i,
   input  logic              pb_read_i,
   input  logic              en_we_i,
   input  logic [REG_W-1:0]  en_wdata_i,
   input  logic              flag_we_i,
   input  logic [REG_W-1:0]  flag_wdata_i,
   input  logic              irq_ack_i,
   input  logic              sleep_i,
   output logic [REG_W-1:0]  en_o,
   output logic [REG_W-1:0]  flag_o,
   output logic              irq_req_o,
   output logic [PC_W-1:0]   irq_vec_o,
   output logic              wake_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PB_W < 1 || PB_W > REG_W) begin : g_bad_pbw
         $error("PB_W must lie in 1..REG_W");
      end
      if (PC_W < 4 || PC_W > 16) begin : g_bad_pcw
         $error("PC_W must lie in 4..16");
      end
   endgenerate

   logic [PB_W-1:0] pb_sync;
   logic            int_evt;
   logic            pb_chg;
   logic            gie_q;
   src_vec_t        src_en_q;
   src_vec_t        src_set;
   src_vec_t        flags_q;
   logic            unused_wbits;

   assign unused_wbits = ^{en_wdata_i[6:3], flag_wdata_i[7:3]};

   irq_sync #(.W(PB_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pb_pins_i), .q(pb_sync)
   );

   irq_int_edge u_int (
      .clk(clk), .rst_n(rst_n), .pin(pb_sync[0]),
      .rise_sel(int_rise_i), .evt(int_evt)
   );

   irq_pb_change #(.W(PB_W)) u_chg (
      .clk(clk), .rst_n(rst_n), .pins(pb_sync), .wake_en(wake_en_i),
      .snap_ld(pb_read_i), .change(pb_chg)
   );

   always_comb begin
      src_set          = '0;
      src_set[T0_BIT]  = tmr_ovf_i;
      src_set[PB_BIT]  = pb_chg;
      src_set[INT_BIT] = int_evt;
   end

   irq_src_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set(src_set), .we(flag_we_i),
      .wdata(flag_wdata_i[NSRC-1:0]), .q(flags_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q    <= 1'b0;
         src_en_q <= '0;
      end else begin
         if (en_we_i) begin
            src_en_q <= en_wdata_i[NSRC-1:0];
            gie_q    <= en_wdata_i[GIE_BIT];
         end
         if (irq_ack_i) gie_q <= 1'b0;
      end
   end

   always_comb begin
      en_o                = '0;
      en_o[NSRC-1:0]      = src_en_q;
      en_o[GIE_BIT]       = gie_q;
      flag_o              = '0;
      flag_o[NSRC-1:0]    = flags_q;
   end

   assign irq_req_o = gie_q & (|(flags_q & src_en_q));
   assign irq_vec_o = HW_VECTOR[PC_W-1:0];
   assign wake_o    = sleep_i & (flags_q[INT_BIT] | flags_q[PB_BIT]);
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tmr_ovf_i,
   input logic       flag_we_i,
   input logic       irq_ack_i,
   input logic       sleep_i,
   input logic [7:0] en_o,
   input logic [7:0] flag_o,
   input logic       irq_req_o,
   input logic       wake_o
);
   a_r3_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i |=> flag_o[0]);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[0] && !flag_we_i) |=> flag_o[0]);

   a_r8_no_req_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !en_o[7] |-> !irq_req_o);

   a_r9_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_i |=> !en_o[7] && !irq_req_o);

   a_r10_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |-> !wake_o);

   a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[7:3] == 5'd0 && en_o[6:3] == 4'd0);
endmodule

bind irq_wake_ctrl irq_wake_chk u_chk (.*);

// File: tb/tb_irq_wake_ctrl.sv
module tb_irq_wake_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_ovf_i = 1'b0;
   logic [7:0]  pb_pins_i = '0;
   logic        int_rise_i = 1'b1;
   logic [7:0]  wake_en_i = '0;
   logic        pb_read_i = 1'b0;
   logic        en_we_i = 1'b0;
   logic [7:0]  en_wdata_i = '0;
   logic        flag_we_i = 1'b0;
   logic [7:0]  flag_wdata_i = '0;
   logic        irq_ack_i = 1'b0;
   logic        sleep_i = 1'b0;
   logic [7:0]  en_o;
   logic [7:0]  flag_o;
   logic        irq_req_o;
   logic [10:0] irq_vec_o;
   logic        wake_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_wake_ctrl dut (.*);

   // {enable write, flag write, expected request}
   localparam logic [16:0] VEC [8] = '{
      {8'h87, 8'h01, 1'b1}, {8'h07, 8'h07, 1'b0},
      {8'h81, 8'h02, 1'b0}, {8'h82, 8'h02, 1'b1},
      {8'h84, 8'h04, 1'b1}, {8'h80, 8'h07, 1'b0},
      {8'h86, 8'h01, 1'b0}, {8'hFF, 8'hF8, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr_en(input logic [7:0] v);
      en_we_i = 1'b1; en_wdata_i = v; tick(); en_we_i = 1'b0;
   endtask

   task automatic wr_flag(input logic [7:0] v);
      flag_we_i = 1'b1; flag_wdata_i = v; tick(); flag_we_i = 1'b0;
   endtask

   task automatic pb_read();
      pb_read_i = 1'b1; tick(); pb_read_i = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      chk("R1 enable reset", en_o, 8'h00);
      chk("R1 flag reset", flag_o, 8'h00);
      chk("R1 request reset", irq_req_o, 1'b0);
      chk("R1 wake reset", wake_o, 1'b0);
      chk("R11 vector", irq_vec_o, 11'h008);

      for (int k = 0; k < 8; k++) begin
         en_we_i = 1'b1; en_wdata_i = VEC[k][16:9];
         flag_we_i = 1'b1; flag_wdata_i = VEC[k][8:1];
         tick();
         en_we_i = 1'b0; flag_we_i = 1'b0;
         chk("R2 enable bits", en_o, VEC[k][16:9] & 8'h87);
         chk("R2 flag bits", flag_o, VEC[k][8:1] & 8'h07);
         chk("R8 request", irq_req_o, VEC[k][0]);
      end
      wr_en(8'h00);
      wr_flag(8'h00);

      // timer source, masked
      tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
      chk("R3 timer flag", flag_o, 8'h01);
      chk("R8 masked timer no request", irq_req_o, 1'b0);
      tick(3);
      chk("R7 flag holds", flag_o, 8'h01);
      flag_we_i = 1'b1; flag_wdata_i = 8'h00; tmr_ovf_i = 1'b1;
      tick();
      flag_we_i = 1'b0; tmr_ovf_i = 1'b0;
      chk("R7 event beats clear", flag_o, 8'h01);
      wr_flag(8'h00);
      chk("R7 software clear", flag_o, 8'h00);

      // external edge
      int_rise_i = 1'b1;
      pb_pins_i = 8'h01; tick(4);
      chk("R4 rising edge sets", flag_o, 8'h04);
      wr_flag(8'h00);
      pb_pins_i = 8'h00; tick(4);
      chk("R4 falling ignored when rising selected", flag_o, 8'h00);
      int_rise_i = 1'b0;
      pb_pins_i = 8'h01; tick(4);
      chk("R4 rising ignored when falling selected", flag_o, 8'h00);
      pb_pins_i = 8'h00; tick(4);
      chk("R4 falling edge sets", flag_o, 8'h04);
      wr_flag(8'h00);
      int_rise_i = 1'b1;

      // port change
      pb_read();
      wake_en_i = 8'h0F;
      pb_pins_i = 8'h10; tick(4);
      chk("R5 disabled pin ignored", flag_o, 8'h00);
      pb_pins_i = 8'h14; tick(4);
      chk("R5 enabled pin change", flag_o, 8'h02);
      wr_flag(8'h00);
      tick();
      chk("R6 clear without read reasserts", flag_o, 8'h02);
      pb_read();
      wr_flag(8'h00);
      tick(3);
      chk("R6 clear after read holds", flag_o, 8'h00);

      // wake while masked
      sleep_i = 1'b1; tick();
      chk("R10 no wake without flag", wake_o, 1'b0);
      pb_pins_i = 8'h10; tick(4);
      chk("R10 wake with interrupts masked", wake_o, 1'b1);
      chk("R8 no request while masked", irq_req_o, 1'b0);
      sleep_i = 1'b0; #1;
      chk("R10 no wake when awake", wake_o, 1'b0);
      pb_read(); wr_flag(8'h00);
      chk("R5 flag cleared after resync", flag_o, 8'h00);

      // acknowledge
      wr_en(8'h87);
      tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
      chk("R8 enabled timer requests", irq_req_o, 1'b1);
      irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
      chk("R9 ack clears global enable", en_o, 8'h07);
      chk("R9 request dropped", irq_req_o, 1'b0);
      chk("R7 flag kept after ack", flag_o, 8'h01);
      en_we_i = 1'b1; en_wdata_i = 8'h80; irq_ack_i = 1'b1;
      tick();
      en_we_i = 1'b0; irq_ack_i = 1'b0;
      chk("R9 ack beats enable write", en_o, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule